// File: doc/BRIEF.md
# Temperature Interrupt Status Controller

This block produces the latched status bits and the interrupt line of a hardware-monitor style sensor. Each time a temperature conversion finishes, the result is compared as a signed value against two thresholds: a hot threshold and an overtemperature threshold, each with its own hysteresis threshold below it. Four external event lines are latched alongside. The thresholds and the temperature arrive as inputs. The converter, the serial bus and the threshold registers live elsewhere.

An 8-bit mask register is written and read through a small register port. Its low six bits keep the matching status bits from driving the interrupt. Its top two bits choose, for each temperature channel, between two modes. In the repeating mode the status bit is raised after every conversion while the channel is hot. In the one-shot mode the status bit is raised once when the channel crosses above its threshold and once more when it drops below its hysteresis threshold. Reading the status register clears every bit.

Top module: `temp_irq_status`

## Requirements
- R1: After reset the mask reads 0x00, the status reads 0x00 and `irq` is low.
- R2: A cycle with `cfg_wr` high loads `cfg_wdata` into the mask, and `cfg_rdata` shows the mask from the next cycle on. Mask bit 6 selects the hot channel mode and bit 7 selects the overtemperature channel mode (1 = one-shot).
- R3: Status bits 1 to 4 latch `ev_in[0]` to `ev_in[3]`. A bit is set on any cycle where its input is high, and it stays set after the input falls until a status read.
- R4: In repeating mode, status bit 0 (hot) or bit 5 (overtemperature) is set after every `conv_done` cycle in which the channel's hot state is 1 after that conversion's update.
- R5: Each channel's hot state becomes 1 when `temp` is above its threshold and 0 when `temp` is below its hysteresis threshold. It keeps its value otherwise. Comparisons are signed two's complement and happen only on `conv_done`.
- R6: In one-shot mode a channel's status bit is set only on a conversion that changes the channel's hot state, whether rising or falling. Repeat conversions above the threshold, and conversions inside the band, set nothing.
- R7: The two temperature channels have independent mode bits and independent thresholds.
- R8: A cycle with `stat_rd` high clears all status bits from the next cycle on. A bit whose event arrives in that same cycle stays set.
- R9: `irq` is a registered, active-high signal that equals the OR over k = 0 to 5 of status bit k AND NOT mask bit k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Mask write strobe |
| cfg_wdata | input | 8 | Mask write data |
| cfg_rdata | output | 8 | Current mask value |
| stat_rd | input | 1 | Status read strobe (clears the status) |
| stat_rdata | output | 6 | Current status: bit0 hot, bits1-4 events, bit5 overtemperature |
| conv_done | input | 1 | Conversion finished strobe |
| temp | input | TW | Converted temperature, signed |
| hot_lim | input | TW | Hot threshold, signed |
| hot_hyst | input | TW | Hot hysteresis threshold, signed |
| os_lim | input | TW | Overtemperature threshold, signed |
| os_hyst | input | TW | Overtemperature hysteresis threshold, signed |
| ev_in | input | 4 | Level event inputs |
| irq | output | 1 | Interrupt, active high |

## Verification
On every cycle the assertions check the mask load, event latching, clear-on-read with the same-cycle event kept, the interrupt equation against status and mask, the repeating-mode set, the hot state holding inside the band, and one-shot silence on repeat hot conversions. The full sequences can only be shown by the bench scenarios: the one-shot rising and falling pair, signed threshold crossings with negative values, two channels running in different modes at once, and masked bits that stay readable while the interrupt stays low.

// File: rtl/temp_irq_status.sv
module temp_irq_status #(
  parameter int TW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  input  logic                 stat_rd,
  output logic [5:0]           stat_rdata,
  input  logic                 conv_done,
  input  logic signed [TW-1:0] temp,
  input  logic signed [TW-1:0] hot_lim,
  input  logic signed [TW-1:0] hot_hyst,
  input  logic signed [TW-1:0] os_lim,
  input  logic signed [TW-1:0] os_hyst,
  input  logic [3:0]           ev_in,
  output logic                 irq
);

  logic [7:0] mask, mask_n;
  logic [5:0] status, stat_n, set;
  logic [1:0] above, above_n, tset, mode;
  logic       irq_q;

  function automatic logic nxt_above(input logic cur, input logic signed [TW-1:0] t,
                                     input logic signed [TW-1:0] lim,
                                     input logic signed [TW-1:0] hy);
    if (t > lim) return 1'b1;
    if (t < hy) return 1'b0;
    return cur;
  endfunction

  assign mode       = mask[7:6];
  assign above_n[0] = conv_done ? nxt_above(above[0], temp, hot_lim, hot_hyst) : above[0];
  assign above_n[1] = conv_done ? nxt_above(above[1], temp, os_lim, os_hyst) : above[1];

  for (genvar i = 0; i < 2; i++) begin : g_ch
    assign tset[i] = conv_done & (mode[i] ? (above_n[i] ^ above[i]) : above_n[i]);
  end

  assign set    = {tset[1], ev_in, tset[0]};
  assign stat_n = (stat_rd ? 6'd0 : status) | set;
  assign mask_n = cfg_wr ? cfg_wdata : mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= 8'h00;
      status <= 6'h00;
      above  <= 2'b00;
      irq_q  <= 1'b0;
    end else begin
      mask   <= mask_n;
      status <= stat_n;
      above  <= above_n;
      irq_q  <= |(stat_n & ~mask_n[5:0]);
    end
  end

  assign cfg_rdata  = mask;
  assign stat_rdata = status;
  assign irq        = irq_q;

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata == $past(cfg_wdata));

  // R3
  ev_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_in) |=> ((stat_rdata[4:1] & $past(ev_in)) == $past(ev_in)));

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !conv_done && ev_in == 4'd0) |=> stat_rdata == 6'd0);

  // R8
  rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && ev_in[3]) |=> stat_rdata[4]);

  // R9
  irq_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(stat_rdata & ~cfg_rdata[5:0]));

  // R4
  default_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !mask[6] && temp > hot_lim) |=> stat_rdata[0]);

  // R5
  band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && temp <= hot_lim && temp >= hot_hyst) |=> above[0] == $past(above[0]));

  // R6
  one_shot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && mask[6] && above[0] && temp > hot_lim && !stat_rd)
      |=> stat_rdata[0] == $past(stat_rdata[0]));

endmodule

// File: tb/sim_temp_irq_status.sv
module sim_temp_irq_status;
  localparam int PER = 10;

  logic clk = 0, rst_n = 0, cfg_wr = 0, stat_rd = 0, conv_done = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [5:0] stat_rdata;
  logic signed [7:0] temp = 0, hot_lim = 50, hot_hyst = 45, os_lim = 80, os_hyst = 70;
  logic [3:0] ev_in = 0;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [5:0] exp_q[$];
  string tag_q[$];

  always #(PER/2) clk = ~clk;

  temp_irq_status #(.TW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .stat_rd(stat_rd), .stat_rdata(stat_rdata), .conv_done(conv_done), .temp(temp),
    .hot_lim(hot_lim), .hot_hyst(hot_hyst), .os_lim(os_lim), .os_hyst(os_hyst),
    .ev_in(ev_in), .irq(irq));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    @(negedge clk);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic conv(logic signed [7:0] t);
    conv_done = 1; temp = t; tick(); conv_done = 0;
  endtask

  task automatic rd(logic [5:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    stat_rd = 1; tick(); stat_rd = 0;
  endtask

  task automatic wr_mask(logic [7:0] v);
    cfg_wr = 1; cfg_wdata = v; tick(); cfg_wr = 0;
  endtask

  always @(negedge clk) begin
    if (stat_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: actual=%0h expected=none", stat_rdata);
      end else begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (stat_rdata != e) begin
          errors++;
          $display("FAIL %s: actual=%0h expected=%0h", t, stat_rdata, e);
        end
      end
    end
  end

  initial begin
    #(PER * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 mask", cfg_rdata, 0);
    chk("R1 status", stat_rdata, 0);
    chk("R1 irq", irq, 0);
    tick();
    conv(8'sd40);               rd(6'h00, "R4 below limit");
    conv(8'sd60);               chk("R9 irq raised", irq, 1);
    rd(6'h01, "R4 above limit");
    chk("R9 irq after read", irq, 0);
    conv(8'sd47);               rd(6'h01, "R5 band keeps hot, R4 repeats");
    conv(8'sd40);               rd(6'h00, "R5 below hysteresis");
    conv(-8'sd16);              rd(6'h00, "R5 signed compare");
    ev_in = 4'b0001; tick(); ev_in = 0; tick(); tick();
    rd(6'h02, "R3 event 0 held");
    ev_in = 4'b1000; tick(); ev_in = 0;
    rd(6'h10, "R3 event 3");
    wr_mask(8'h01);             chk("R2 mask readback", cfg_rdata, 8'h01);
    conv(8'sd60);               chk("R9 masked irq", irq, 0);
    rd(6'h01, "R9 masked bit readable");
    conv(8'sd40);               rd(6'h00, "R5 drop");
    wr_mask(8'h40);
    conv(8'sd60);               rd(6'h01, "R6 one-shot rise");
    conv(8'sd60);               rd(6'h00, "R6 one-shot repeat silent");
    conv(8'sd47);               rd(6'h00, "R6 band silent");
    conv(8'sd40);               rd(6'h01, "R6 one-shot fall");
    conv(8'sd40);               rd(6'h00, "R6 after fall");
    conv(8'sd90);               rd(6'h21, "R7 both channels");
    conv(8'sd90);               rd(6'h20, "R7 os repeats, hot one-shot");
    ev_in = 4'b0010; tick(); ev_in = 0;
    chk("R9 event irq", irq, 1);
    ev_in = 4'b0100; rd(6'h04, "R8 read with new event"); ev_in = 0;
    rd(6'h08, "R8 same-cycle event kept");
    wr_mask(8'h3F);
    ev_in = 4'b1000; tick(); ev_in = 0;
    chk("R9 all masked", irq, 0);
    rd(6'h10, "R3 masked event latched");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule